// File: doc/BRIEF.md
# Fault-Mapped Reset Output Controller

This block decides when a supervisor's active-low reset line is pulled down. From power-on it holds the line low until the built-in self test reports that it has finished. After that the line stays released, held high by the external pull-up, until a fault source that software has mapped to reset becomes active. The mappable sources are a watchdog fault, an error-signal-monitor fault that arrives already qualified by that monitor's own delay, and per-channel overvoltage and undervoltage faults. When every mapped fault has cleared, the line stays low for a programmable hold-off time and only then is released.

The block also reads the pin level back through a two-flop synchronizer and compares it with the level it intends. After every change of the driven level the comparison is blanked for 2 µs so the pin can settle. Any disagreement after that sets a sticky mismatch flag, which is cleared by a write-one-to-clear pulse.

Time is counted in 1 µs ticks from a clock prescaler. The parameter `DLY_DIV` divides every hold-off length so that a scaled copy can be used for short runs. Its default of 1 gives true microseconds.

Top module: `rstout_ctrl`

## Requirements
- R1: From reset until `bist_done` is first seen high, `rst_drive_low` is 1 whatever the fault inputs are. `mm_flag` is 0 after reset.
- R2: After `bist_done` is seen with no mapped fault active, `rst_drive_low` goes to 0 and stays 0 while no mapped fault is active.
- R3: `wd_flt` asserts reset (`rst_drive_low`=1 on the next cycle) only while `wd_en` is 1. With `wd_en`=0 it has no effect on the output.
- R4: `esm_flt` (already qualified) asserts reset only while `esm_en` is 1. With `esm_en`=0 it has no effect.
- R5: Bit i of `ov_flt` or `uv_flt` asserts reset only while bit i of `ov_en` or `uv_en` respectively is 1. A fault on a channel whose enable bit is 0 has no effect.
- R6: Once all mapped faults clear, reset stays low for T ticks of 1 µs, then it is released. T is the value below for the given `dly_sel`, divided by `DLY_DIV` (minimum 1): 0→200, 1→1000, 2→2000, 3→5000, 4→10000, 5→20000, 6→100000, 7→200000. One tick lasts `TICK_DIV` clocks.
- R7: If any mapped fault reasserts during the hold-off, reset stays low and the hold-off count restarts from zero when the fault clears again.
- R8: When the synchronized pin level differs from the intended level (released = high, driven = low) outside the blanking window, `mm_flag` sets and stays set until cleared.
- R9: For 2 µs (2·`TICK_DIV` clocks) after each change of `rst_drive_low`, no mismatch is detected.
- R10: A 1 on `mm_clr` clears `mm_flag` on the next cycle, unless a mismatch is detected in the same cycle. In that case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| bist_done | input | 1 | Self test finished |
| wd_flt | input | 1 | Watchdog fault |
| wd_en | input | 1 | Map watchdog fault to reset |
| esm_flt | input | 1 | Qualified error-signal-monitor fault |
| esm_en | input | 1 | Map monitor fault to reset |
| ov_flt | input | NCH | Per-channel overvoltage faults |
| ov_en | input | NCH | Per-channel overvoltage mapping |
| uv_flt | input | NCH | Per-channel undervoltage faults |
| uv_en | input | NCH | Per-channel undervoltage mapping |
| dly_sel | input | 3 | Hold-off length select |
| pin_lvl | input | 1 | Sensed pin level (asynchronous) |
| mm_clr | input | 1 | Write-one-to-clear for the mismatch flag |
| rst_drive_low | output | 1 | 1 = pull the reset pin low |
| mm_flag | output | 1 | Sticky pin mismatch flag |

## Verification
Two functions can act on the sticky flag in the same cycle: a clear pulse and a fresh mismatch detection. The bench holds the pin low against a released output while it pulses `mm_clr`, and it expects the flag to stay set. A second coincidence lines up the end of the hold-off with a pin that stays low. Here the bench checks that the flag is still clear inside the blanking window and set once the window has passed. The reference model predicts both outputs on every clock from the requirements alone.

// File: rtl/rstout_pkg.sv
package rstout_pkg;

    typedef enum logic [1:0] {
        ST_SELFTEST = 2'd0,
        ST_RELEASED = 2'd1,
        ST_ASSERT   = 2'd2,
        ST_HOLDOFF  = 2'd3
    } rst_state_e;

    localparam int unsigned MAX_DLY_US = 200000;
    localparam int unsigned DLY_CW     = $clog2(MAX_DLY_US + 1);

    // Hold-off length in microseconds for each select code
    function automatic int unsigned dly_us(input logic [2:0] sel);
        int unsigned v;
        case (sel)
            3'd0:    v = 200;
            3'd1:    v = 1000;
            3'd2:    v = 2000;
            3'd3:    v = 5000;
            3'd4:    v = 10000;
            3'd5:    v = 20000;
            3'd6:    v = 100000;
            default: v = 200000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rstout_tick.sv
module rstout_tick #(
    parameter int unsigned TICK_DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == LAST) r_d.cnt = '0;
        else                 r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = (r_q.cnt == LAST);
endmodule

// File: rtl/rstout_seq.sv
module rstout_seq
    import rstout_pkg::*;
#(
    parameter int unsigned NCH     = 4,
    parameter int unsigned DLY_DIV = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           bist_done,
    input  logic           wd_flt,
    input  logic           wd_en,
    input  logic           esm_flt,
    input  logic           esm_en,
    input  logic [NCH-1:0] ov_flt,
    input  logic [NCH-1:0] ov_en,
    input  logic [NCH-1:0] uv_flt,
    input  logic [NCH-1:0] uv_en,
    input  logic [2:0]     dly_sel,
    output logic           drive_low
);
    typedef struct packed {
        rst_state_e       st;
        logic [DLY_CW-1:0] hold;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic              fault_any;
    logic [DLY_CW-1:0] target;
    int unsigned       scaled;

    always_comb begin
        fault_any = (wd_flt & wd_en) | (esm_flt & esm_en)
                  | (|(ov_flt & ov_en)) | (|(uv_flt & uv_en));
        scaled = dly_us(dly_sel) / DLY_DIV;
        if (scaled == 0) scaled = 1;
        target = DLY_CW'(scaled);
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_SELFTEST: begin
                if (bist_done) r_d.st = fault_any ? ST_ASSERT : ST_RELEASED;
            end
            ST_RELEASED: begin
                if (fault_any) r_d.st = ST_ASSERT;
            end
            ST_ASSERT: begin
                if (!fault_any) begin
                    r_d.st   = ST_HOLDOFF;
                    r_d.hold = '0;
                end
            end
            default: begin
                if (fault_any) begin
                    r_d.st = ST_ASSERT;
                end else if (tick) begin
                    if (r_q.hold + 1'b1 >= target) begin
                        r_d.st   = ST_RELEASED;
                        r_d.hold = '0;
                    end else begin
                        r_d.hold = r_q.hold + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_SELFTEST;
            r_q.hold <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_low = (r_q.st != ST_RELEASED);
endmodule

// File: rtl/rstout_pinchk.sv
module rstout_pinchk #(
    parameter int unsigned BLANK_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_low,
    input  logic pin_lvl,
    input  logic mm_clr,
    output logic mm_flag
);
    localparam int unsigned BW = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic [BW-1:0] blank;
        logic          flag;
    } chk_regs_t;

    chk_regs_t r_q, r_d;
    logic      changed, detect;

    always_comb begin
        r_d     = r_q;
        changed = (drive_low != r_q.prev);
        detect  = !changed && (r_q.blank == '0) && (r_q.s2 != !drive_low);
        r_d.s1   = pin_lvl;
        r_d.s2   = r_q.s1;
        r_d.prev = drive_low;
        if (changed)                r_d.blank = BW'(BLANK_CYC);
        else if (r_q.blank != '0)   r_d.blank = r_q.blank - 1'b1;
        r_d.flag = (r_q.flag & ~mm_clr) | detect;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.s1    <= 1'b0;
            r_q.s2    <= 1'b0;
            r_q.prev  <= 1'b1;
            r_q.blank <= '0;
            r_q.flag  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mm_flag = r_q.flag;
endmodule

// File: rtl/rstout_ctrl.sv
module rstout_ctrl #(
    parameter int unsigned NCH      = 4,
    parameter int unsigned TICK_DIV = 250,
    parameter int unsigned DLY_DIV  = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bist_done,
    input  logic           wd_flt,
    input  logic           wd_en,
    input  logic           esm_flt,
    input  logic           esm_en,
    input  logic [NCH-1:0] ov_flt,
    input  logic [NCH-1:0] ov_en,
    input  logic [NCH-1:0] uv_flt,
    input  logic [NCH-1:0] uv_en,
    input  logic [2:0]     dly_sel,
    input  logic           pin_lvl,
    input  logic           mm_clr,
    output logic           rst_drive_low,
    output logic           mm_flag
);
    localparam int unsigned BLANK_CYC = 2 * TICK_DIV;

    logic tick;

    rstout_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rstout_seq #(.NCH(NCH), .DLY_DIV(DLY_DIV)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bist_done (bist_done),
        .wd_flt    (wd_flt),
        .wd_en     (wd_en),
        .esm_flt   (esm_flt),
        .esm_en    (esm_en),
        .ov_flt    (ov_flt),
        .ov_en     (ov_en),
        .uv_flt    (uv_flt),
        .uv_en     (uv_en),
        .dly_sel   (dly_sel),
        .drive_low (rst_drive_low)
    );

    rstout_pinchk #(.BLANK_CYC(BLANK_CYC)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_low (rst_drive_low),
        .pin_lvl   (pin_lvl),
        .mm_clr    (mm_clr),
        .mm_flag   (mm_flag)
    );
endmodule

// File: rtl/rstout_ctrl_chk.sv
module rstout_ctrl_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bist_done,
    input logic           wd_flt,
    input logic           wd_en,
    input logic           esm_flt,
    input logic           esm_en,
    input logic [NCH-1:0] ov_flt,
    input logic [NCH-1:0] ov_en,
    input logic [NCH-1:0] uv_flt,
    input logic [NCH-1:0] uv_en,
    input logic           mm_clr,
    input logic           rst_drive_low,
    input logic           mm_flag
);
    logic seen_q;
    logic mapped;

    assign mapped = (wd_flt & wd_en) | (esm_flt & esm_en)
                  | (|(ov_flt & ov_en)) | (|(uv_flt & uv_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen_q <= 1'b0;
        else if (bist_done) seen_q <= 1'b1;
    end

    AST_SELFTEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> rst_drive_low); // R1

    AST_FAULT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |=> rst_drive_low); // R3

    AST_NO_RELEASE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_drive_low && $past(rst_drive_low)) |-> !$past(mapped)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_flag && !mm_clr) |=> mm_flag); // R8

    AST_BLANK_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_drive_low != $past(rst_drive_low)) |=> !$rose(mm_flag)); // R9
endmodule

bind rstout_ctrl rstout_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bist_done     (bist_done),
    .wd_flt        (wd_flt),
    .wd_en         (wd_en),
    .esm_flt       (esm_flt),
    .esm_en        (esm_en),
    .ov_flt        (ov_flt),
    .ov_en         (ov_en),
    .uv_flt        (uv_flt),
    .uv_en         (uv_en),
    .mm_clr        (mm_clr),
    .rst_drive_low (rst_drive_low),
    .mm_flag       (mm_flag)
);

// File: tb/rstout_ctrl_tb_top.sv
`timescale 1ns/1ps
module rstout_ctrl_tb_top;
    localparam int NCH   = 4;
    localparam int TDIV  = 2;
    localparam int DDIV  = 100;
    localparam int BLANK = 2 * TDIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bist_done = 0, wd_flt = 0, wd_en = 0, esm_flt = 0, esm_en = 0;
    logic [NCH-1:0] ov_flt = '0, ov_en = '0, uv_flt = '0, uv_en = '0;
    logic [2:0] dly_sel = '0;
    logic mm_clr = 0, force_low = 0;
    logic pin_lvl, rst_drive_low, mm_flag;

    always #2 clk = ~clk;

    assign pin_lvl = force_low ? 1'b0 : !rst_drive_low;

    rstout_ctrl #(.NCH(NCH), .TICK_DIV(TDIV), .DLY_DIV(DDIV)) dut_i (.*);

    int checks = 0, failures = 0;
    string phase_tag = "R1";
    bit done = 0;

    // behavioural reference: integers, no register structs
    int m_mode;      // 0 self test, 1 released, 2 faulted, 3 counting hold-off
    int m_elapsed, m_phase, m_quiet, m_sync[$];
    bit m_prev, m_flag;

    function automatic int hold_ticks(input int sel);
        int us [8] = '{200, 1000, 2000, 5000, 10000, 20000, 100000, 200000};
        int t = us[sel] / DDIV;
        return (t < 1) ? 1 : t;
    endfunction

    function automatic bit any_fault();
        return (wd_flt && wd_en) || (esm_flt && esm_en) ||
               ((ov_flt & ov_en) != 0) || ((uv_flt & uv_en) != 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_elapsed = 0; m_phase = 0; m_quiet = 0;
            m_sync = '{0, 0}; m_prev = 1; m_flag = 0;
        end else begin
            bit drv, tk, f, det;
            drv = (m_mode != 1);
            tk  = (m_phase == TDIV - 1);
            m_phase = (m_phase + 1) % TDIV;
            f   = any_fault();
            det = (drv == m_prev) && (m_quiet == 0) && (m_sync[1] != !drv);
            if (drv != m_prev) m_quiet = BLANK;
            else if (m_quiet > 0) m_quiet--;
            m_prev = drv;
            m_flag = (m_flag && !mm_clr) || det;
            m_sync = '{pin_lvl, m_sync[0]};
            case (m_mode)
                0: if (bist_done) m_mode = f ? 2 : 1;
                1: if (f) m_mode = 2;
                2: if (!f) begin m_mode = 3; m_elapsed = 0; end
                default: if (f) m_mode = 2;
                         else if (tk) begin
                             m_elapsed++;
                             if (m_elapsed >= hold_ticks(int'(dly_sel))) m_mode = 1;
                         end
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase_tag, " model drive"}, rst_drive_low, (m_mode != 1));
            check({phase_tag, " model flag"}, mm_flag, m_flag);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_release(input string tag, input int sel);
        int k = 0;
        while (k < 20000) begin
            @(negedge clk);
            k++;
            if (!rst_drive_low) break;
        end
        check({tag, " hold-off lower"}, int'(k >= 2 * hold_ticks(sel)), 1);
        check({tag, " hold-off upper"}, int'(k <= 2 * hold_ticks(sel) + 1), 1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        cyc(150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cyc(4);
        rst_n = 1;
        phase_tag = "R1";
        wd_flt = 0;
        cyc(20);
        check("R1 held in self test", rst_drive_low, 1);
        check("R1 flag after reset", mm_flag, 0);

        phase_tag = "R2";
        bist_done = 1;
        cyc(3);
        check("R2 released after self test", rst_drive_low, 0);

        phase_tag = "R3";
        wd_flt = 1; wd_en = 0;
        cyc(10);
        check("R3 unmapped watchdog ignored", rst_drive_low, 0);
        wd_en = 1;
        cyc(2);
        check("R3 mapped watchdog asserts", rst_drive_low, 1);
        wd_flt = 0;
        measure_release("R6 code0", 0);

        phase_tag = "R6";
        for (int c = 0; c < 8; c++) begin
            dly_sel = 3'(c);
            case (c % 4)
                0: wd_flt = 1;
                1: begin esm_en = 1; esm_flt = 1; end
                2: begin ov_en = 4'b0100; ov_flt = 4'b0100; end
                default: begin uv_en = 4'b1000; uv_flt = 4'b1000; end
            endcase
            cyc(3);
            check((c % 2) ? "R4/R5 mapped source asserts" : "R3/R5 mapped source asserts",
                  rst_drive_low, 1);
            wd_flt = 0; esm_flt = 0; ov_flt = '0; uv_flt = '0;
            measure_release("R6 table", c);
            cyc(3);
        end

        phase_tag = "R5";
        dly_sel = 0;
        ov_en = 4'b0001; ov_flt = 4'b0010;
        uv_en = 4'b0001; uv_flt = 4'b0100;
        cyc(10);
        check("R5 unmapped channel ignored", rst_drive_low, 0);
        ov_flt = '0; uv_flt = '0;

        phase_tag = "R4";
        esm_en = 0; esm_flt = 1;
        cyc(10);
        check("R4 unmapped monitor fault ignored", rst_drive_low, 0);
        esm_flt = 0;

        phase_tag = "R7";
        dly_sel = 3;
        wd_flt = 1;
        cyc(3);
        wd_flt = 0;
        cyc(60);
        check("R7 still holding", rst_drive_low, 1);
        wd_flt = 1;
        cyc(1);
        wd_flt = 0;
        measure_release("R7 restart", 3);

        phase_tag = "R8";
        cyc(3);
        force_low = 1;
        cyc(6);
        check("R8 mismatch detected", mm_flag, 1);
        force_low = 0;
        cyc(5);
        check("R8 flag sticky", mm_flag, 1);
        phase_tag = "R10";
        mm_clr = 1; cyc(1); mm_clr = 0; cyc(1);
        check("R10 clear works", mm_flag, 0);

        force_low = 1;
        cyc(6);
        mm_clr = 1;
        cyc(2);
        check("R10 detect wins over clear", mm_flag, 1);
        mm_clr = 0; force_low = 0;
        cyc(4);
        mm_clr = 1; cyc(1); mm_clr = 0; cyc(1);
        check("R10 clear after pin recovers", mm_flag, 0);

        phase_tag = "R9";
        dly_sel = 0;
        wd_flt = 1;
        cyc(3);
        force_low = 1;
        cyc(3);
        check("R9 no mismatch while driven low", mm_flag, 0);
        wd_flt = 0;
        while (rst_drive_low) @(negedge clk);
        cyc(4);
        check("R9 blanked after release", mm_flag, 0);
        cyc(6);
        check("R9 detected after blanking", mm_flag, 1);
        force_low = 0;
        cyc(3);
        mm_clr = 1; cyc(1); mm_clr = 0; cyc(3);
        check("R10 final clear", mm_flag, 0);

        finish_run();
    end
endmodule